// File: doc/BRIEF.md
# Flag-Generating Adder-Subtractor

This block adds or subtracts two WIDTH-bit two's-complement operands on one ripple carry chain. A single `sub` control does two things. It inverts every bit of the second operand, and it feeds a one into the carry input of the lowest stage, so the chain computes `op_a + ~op_b + 1`. The sum or difference leaves the block combinationally on `result`.

Four condition flags come from the same cycle's chain:

- sign (N): the top result bit.
- zero (Z): all result bits are clear.
- carry (C): the carry out of the top stage.
- overflow (V): the carry out of the top stage XOR the carry into it.

A status register captures these flags on a rising edge only when `set_flags` is high.

Six relation outputs are decoded from the registered flags alone, in the manner a processor tests a comparison made by subtraction. Two are unsigned (higher, lower), three are signed (greater-or-equal, less-than, greater-than), and one reports equality. A typical use is a compare step: subtract with `set_flags` high, then read the relations on the following cycle.

Top module: `addsub_flags`

## Requirements
- R1: `result` equals `op_a + op_b` modulo 2^WIDTH when `sub`=0, and `op_a - op_b` modulo 2^WIDTH when `sub`=1, in the same cycle as the inputs.
- R2: The captured sign flag N equals bit WIDTH-1 of the result.
- R3: The captured zero flag Z is 1 exactly when every result bit is 0.
- R4: The captured carry flag C is the unsigned carry out of an addition. After a subtraction it is 1 when `op_a >= op_b` unsigned (no borrow) and 0 on a borrow.
- R5: The captured overflow flag V is 1 exactly when the true signed sum or difference lies outside -2^(WIDTH-1) .. 2^(WIDTH-1)-1. It is never set when `op_a` and the effective second operand (`op_b` XOR `sub`, at the sign bit) differ in sign.
- R6: Flags change only on a rising edge with `set_flags`=1. With `set_flags`=0 they hold their previous values.
- R7: A synchronous active-high `rst` clears all four flags. From the cleared flags the relations read eq=0, hi=0, lo=1, ge=1, lt=0, gt=1.
- R8: `cmp_eq` is Z. After a captured subtraction it is 1 exactly when the operands were equal.
- R9: `cmp_hi` is C AND NOT Z, and `cmp_lo` is NOT C. After a captured subtraction they report unsigned `op_a > op_b` and `op_a < op_b`.
- R10: `cmp_ge` is (N == V) and `cmp_lt` is (N != V). After a captured subtraction they report signed `op_a >= op_b` and `op_a < op_b`.
- R11: `cmp_gt` is (N == V) AND NOT Z. After a captured subtraction it reports signed `op_a > op_b`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the flags |
| op_a | input | WIDTH | First operand (minuend on subtract) |
| op_b | input | WIDTH | Second operand (subtrahend on subtract) |
| sub | input | 1 | 0 = add, 1 = subtract |
| set_flags | input | 1 | Capture the new flags at the next rising edge |
| result | output | WIDTH | Combinational sum or difference |
| flag_n | output | 1 | Registered sign flag |
| flag_z | output | 1 | Registered zero flag |
| flag_c | output | 1 | Registered carry / no-borrow flag |
| flag_v | output | 1 | Registered signed overflow flag |
| cmp_eq | output | 1 | Equal |
| cmp_hi | output | 1 | Unsigned higher |
| cmp_lo | output | 1 | Unsigned lower |
| cmp_ge | output | 1 | Signed greater or equal |
| cmp_lt | output | 1 | Signed less than |
| cmp_gt | output | 1 | Signed greater than |

## Verification
In any one cycle, `result` already shows the new operation while the relation outputs still decode the flags captured from an earlier one. Every operation is therefore judged twice: the result half a cycle after the operands are driven, and the flags and relations one edge later.

Operations with `set_flags` low are interleaved between captured ones, so a fresh result coincides with flags that must not move. The bench keeps its own model of the held flags and expects the relations of the older comparison to persist. The 4-bit configuration is swept over every operand pair in both modes, and the 8-bit configuration is driven with random operands plus the signed-overflow corner pairs.

// File: rtl/addsub_flags_pkg.sv
package addsub_flags_pkg;

    // Condition flags held in the status register.
    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    // Relations decoded from the held flags.
    typedef struct packed {
        logic eq;
        logic hi;
        logic lo;
        logic ge;
        logic lt;
        logic gt;
    } rel_t;

    localparam nzcv_t NZCV_CLEAR = '{n: 1'b0, z: 1'b0, c: 1'b0, v: 1'b0};

    // Relations as a subtract-based compare reads them.
    function automatic rel_t decode_rel(input nzcv_t f);
        rel_t r;
        r.eq = f.z;
        r.hi = f.c & ~f.z;
        r.lo = ~f.c;
        r.ge = ~(f.n ^ f.v);
        r.lt = f.n ^ f.v;
        r.gt = ~(f.n ^ f.v) & ~f.z;
        return r;
    endfunction

endpackage

// File: rtl/fa_cell.sv
module fa_cell (
    input  logic a,
    input  logic b,
    input  logic ci,
    output logic s,
    output logic co
);
    logic p;

    assign p  = a ^ b;
    assign s  = p ^ ci;
    assign co = (a & b) | (p & ci);
endmodule

// File: rtl/operand_cond.sv
module operand_cond #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] b_in,
    input  logic             invert,
    output logic [WIDTH-1:0] b_out
);
    // One XOR per bit: pass on add, complement on subtract.
    for (genvar i = 0; i < WIDTH; i++) begin : g_inv
        assign b_out[i] = b_in[i] ^ invert;
    end
endmodule

// File: rtl/carry_chain.sv
module carry_chain #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             c_top,
    output logic             c_into_top
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0] c;

    assign c[0] = cin;

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        fa_cell u_fa (
            .a  (x[i]),
            .b  (y[i]),
            .ci (c[i]),
            .s  (sum[i]),
            .co (c[i+1])
        );
    end

    assign c_top      = c[WIDTH];
    assign c_into_top = c[MSB];
endmodule

// File: rtl/status_reg.sv
module status_reg
    import addsub_flags_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  nzcv_t d,
    output nzcv_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= NZCV_CLEAR;
        end else if (we) begin
            q <= d;
        end
    end
endmodule

// File: rtl/rel_decode.sv
module rel_decode
    import addsub_flags_pkg::*;
(
    input  nzcv_t f,
    output rel_t  rel
);
    always_comb rel = decode_rel(f);
endmodule

// File: rtl/addsub_flags.sv
module addsub_flags
    import addsub_flags_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             sub,
    input  logic             set_flags,
    output logic [WIDTH-1:0] result,
    output logic             flag_n,
    output logic             flag_z,
    output logic             flag_c,
    output logic             flag_v,
    output logic             cmp_eq,
    output logic             cmp_hi,
    output logic             cmp_lo,
    output logic             cmp_ge,
    output logic             cmp_lt,
    output logic             cmp_gt
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH-1:0] sum;
    logic             c_top;
    logic             c_into_top;
    nzcv_t            live_f;
    nzcv_t            held_f;
    rel_t             rel;

    operand_cond #(.WIDTH(WIDTH)) u_cond (
        .b_in   (op_b),
        .invert (sub),
        .b_out  (b_eff)
    );

    carry_chain #(.WIDTH(WIDTH)) u_chain (
        .x          (op_a),
        .y          (b_eff),
        .cin        (sub),
        .sum        (sum),
        .c_top      (c_top),
        .c_into_top (c_into_top)
    );

    always_comb begin
        live_f.n = sum[MSB];
        live_f.z = ~|sum;
        live_f.c = c_top;
        live_f.v = c_top ^ c_into_top;
    end

    status_reg u_stat (
        .clk (clk),
        .rst (rst),
        .we  (set_flags),
        .d   (live_f),
        .q   (held_f)
    );

    rel_decode u_rel (
        .f   (held_f),
        .rel (rel)
    );

    assign result = sum;
    assign flag_n = held_f.n;
    assign flag_z = held_f.z;
    assign flag_c = held_f.c;
    assign flag_v = held_f.v;
    assign cmp_eq = rel.eq;
    assign cmp_hi = rel.hi;
    assign cmp_lo = rel.lo;
    assign cmp_ge = rel.ge;
    assign cmp_lt = rel.lt;
    assign cmp_gt = rel.gt;
endmodule

// File: rtl/addsub_flags_chk.sv
module addsub_flags_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic             sub,
    input logic             set_flags,
    input logic [WIDTH-1:0] result,
    input logic             flag_n,
    input logic             flag_z,
    input logic             flag_c,
    input logic             flag_v,
    input logic             cmp_eq,
    input logic             cmp_hi,
    input logic             cmp_lo,
    input logic             cmp_ge,
    input logic             cmp_lt,
    input logic             cmp_gt
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0] ext_add;

    assign ext_add = {1'b0, op_a} + {1'b0, op_b};

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> ({flag_n, flag_z, flag_c, flag_v} == 4'b0000)); // R7

    AST_HOLD_FLAGS: assert property (@(posedge clk) disable iff (rst)
        !set_flags |=> $stable({flag_n, flag_z, flag_c, flag_v})); // R6

    AST_SIGN_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        set_flags |=> (flag_n == $past(result[MSB]))); // R2

    AST_ZERO_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        set_flags |=> (flag_z == ($past(result) == '0))); // R3

    AST_ADD_CARRY: assert property (@(posedge clk) disable iff (rst)
        (set_flags && !sub) |=> (flag_c == $past(ext_add[WIDTH]))); // R4

    AST_SUB_NO_BORROW: assert property (@(posedge clk) disable iff (rst)
        (set_flags && sub) |=> (flag_c == $past(op_a >= op_b))); // R4

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (set_flags && (op_a[MSB] != (op_b[MSB] ^ sub))) |=> !flag_v); // R5

    AST_HI_LO_EXCL: assert property (@(posedge clk) disable iff (rst)
        cmp_hi |-> !cmp_lo); // R9

    AST_GE_LT_SPLIT: assert property (@(posedge clk) disable iff (rst)
        cmp_ge != cmp_lt); // R10

    AST_GT_IN_GE: assert property (@(posedge clk) disable iff (rst)
        cmp_gt |-> (cmp_ge && !cmp_eq)); // R11
endmodule

bind addsub_flags addsub_flags_chk #(.WIDTH(WIDTH)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .op_a      (op_a),
    .op_b      (op_b),
    .sub       (sub),
    .set_flags (set_flags),
    .result    (result),
    .flag_n    (flag_n),
    .flag_z    (flag_z),
    .flag_c    (flag_c),
    .flag_v    (flag_v),
    .cmp_eq    (cmp_eq),
    .cmp_hi    (cmp_hi),
    .cmp_lo    (cmp_lo),
    .cmp_ge    (cmp_ge),
    .cmp_lt    (cmp_lt),
    .cmp_gt    (cmp_gt)
);

// File: tb/addsub_flags_tb_top.sv
`timescale 1ns/1ps
module addsub_flags_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [3:0] a4 = '0, b4 = '0, r4;
    logic       s4 = 1'b0, sf4 = 1'b0;
    logic       n4, z4, c4, v4, eq4, hi4, lo4, ge4, lt4, gt4;
    logic [7:0] a8 = '0, b8 = '0, r8;
    logic       s8 = 1'b0, sf8 = 1'b0;
    logic       n8, z8, c8, v8, eq8, hi8, lo8, ge8, lt8, gt8;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    logic [3:0] model4 = 4'b0000;  // {N,Z,C,V}
    logic [3:0] model8 = 4'b0000;

    addsub_flags #(.WIDTH(4)) dut_i (
        .clk(clk), .rst(rst), .op_a(a4), .op_b(b4), .sub(s4), .set_flags(sf4),
        .result(r4), .flag_n(n4), .flag_z(z4), .flag_c(c4), .flag_v(v4),
        .cmp_eq(eq4), .cmp_hi(hi4), .cmp_lo(lo4), .cmp_ge(ge4), .cmp_lt(lt4), .cmp_gt(gt4)
    );

    addsub_flags #(.WIDTH(8)) dut8_i (
        .clk(clk), .rst(rst), .op_a(a8), .op_b(b8), .sub(s8), .set_flags(sf8),
        .result(r8), .flag_n(n8), .flag_z(z8), .flag_c(c8), .flag_v(v8),
        .cmp_eq(eq8), .cmp_hi(hi8), .cmp_lo(lo8), .cmp_ge(ge8), .cmp_lt(lt8), .cmp_gt(gt8)
    );

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0d exp=%0d at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic report();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    // One operation: result checked in-cycle, flags and relations one edge later.
    task automatic apply(input int w, input int ua_in, input int ub_in, input bit s, input bit sf);
        int mask, half, ua, ub, er, sa, sb, sr, gr;
        bit en, ez, ec, ev;
        logic [3:0] exp_f, gf;
        logic [5:0] gp;
        mask = (1 << w) - 1;
        half = 1 << (w - 1);
        ua = ua_in & mask;
        ub = ub_in & mask;
        er = (s ? ua - ub : ua + ub) & mask;
        sa = (ua >= half) ? ua - (1 << w) : ua;
        sb = (ub >= half) ? ub - (1 << w) : ub;
        sr = s ? sa - sb : sa + sb;
        ev = (sr > half - 1) || (sr < -half);
        ec = s ? (ua >= ub) : ((ua + ub) > mask);
        en = (er >= half);
        ez = (er == 0);
        @(negedge clk);
        if (w == 4) begin
            a4 = ua[3:0]; b4 = ub[3:0]; s4 = s; sf4 = sf;
        end else begin
            a8 = ua[7:0]; b8 = ub[7:0]; s8 = s; sf8 = sf;
        end
        #1;
        gr = (w == 4) ? int'(r4) : int'(r8);
        chk($sformatf("R1 result w=%0d a=%0d b=%0d sub=%0d", w, ua, ub, s), gr, er);
        if (sf) exp_f = {en, ez, ec, ev};
        else    exp_f = (w == 4) ? model4 : model8;
        if (w == 4) model4 = exp_f; else model8 = exp_f;
        @(negedge clk);
        sf4 = 1'b0;
        sf8 = 1'b0;
        gf = (w == 4) ? {n4, z4, c4, v4} : {n8, z8, c8, v8};
        gp = (w == 4) ? {eq4, hi4, lo4, ge4, lt4, gt4} : {eq8, hi8, lo8, ge8, lt8, gt8};
        if (sf) begin
            chk($sformatf("R2 N w=%0d a=%0d b=%0d sub=%0d", w, ua, ub, s), int'(gf[3]), int'(exp_f[3]));
            chk($sformatf("R3 Z w=%0d a=%0d b=%0d sub=%0d", w, ua, ub, s), int'(gf[2]), int'(exp_f[2]));
            chk($sformatf("R4 C w=%0d a=%0d b=%0d sub=%0d", w, ua, ub, s), int'(gf[1]), int'(exp_f[1]));
            chk($sformatf("R5 V w=%0d a=%0d b=%0d sub=%0d", w, ua, ub, s), int'(gf[0]), int'(exp_f[0]));
        end else begin
            chk($sformatf("R6 hold w=%0d a=%0d b=%0d", w, ua, ub), int'(gf), int'(exp_f));
        end
        if (sf && s) begin
            chk($sformatf("R8 eq a=%0d b=%0d", ua, ub), int'(gp[5]), int'(ua == ub));
            chk($sformatf("R9 hi a=%0d b=%0d", ua, ub), int'(gp[4]), int'(ua > ub));
            chk($sformatf("R9 lo a=%0d b=%0d", ua, ub), int'(gp[3]), int'(ua < ub));
            chk($sformatf("R10 ge sa=%0d sb=%0d", sa, sb), int'(gp[2]), int'(sa >= sb));
            chk($sformatf("R10 lt sa=%0d sb=%0d", sa, sb), int'(gp[1]), int'(sa < sb));
            chk($sformatf("R11 gt sa=%0d sb=%0d", sa, sb), int'(gp[0]), int'(sa > sb));
        end
    endtask

    task automatic check_reset_state();
        chk("R7 flags4 cleared", int'({n4, z4, c4, v4}), 0);
        chk("R7 flags8 cleared", int'({n8, z8, c8, v8}), 0);
        chk("R7 relations4 {eq,hi,lo,ge,lt,gt}", int'({eq4, hi4, lo4, ge4, lt4, gt4}), 6'b001101);
        model4 = 4'b0000;
        model8 = 4'b0000;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_reset_state();

        // Named corner cases
        apply(4, 7, 5, 1'b1, 1'b1);
        apply(4, 5, 7, 1'b1, 1'b1);
        apply(4, 10, 13, 1'b1, 1'b1);
        apply(8, 72, 57, 1'b0, 1'b1);      // +72 + +57 overflows (R5)
        apply(8, 129, 250, 1'b0, 1'b1);    // -127 + -6 overflows (R5)
        apply(8, 200, 100, 1'b1, 1'b0);    // held: R6

        // Exhaustive 4-bit sweep with interleaved non-capturing operations
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                for (int s = 0; s < 2; s++) begin
                    apply(4, a, b, s[0], ((a + b + s) % 5) != 0);
                end
            end
        end

        // Mid-run reset (R7)
        apply(4, 8, 1, 1'b1, 1'b1);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_reset_state();

        // Random 8-bit
        for (int i = 0; i < 1500; i++) begin
            apply(8, int'($urandom_range(255)), int'($urandom_range(255)),
                  $urandom_range(1) == 1, $urandom_range(7) != 0);
        end
        apply(8, 128, 1, 1'b1, 1'b1);   // -128 - 1 overflows
        apply(8, 127, 255, 1'b1, 1'b1); // 127 - (-1) overflows
        apply(8, 128, 128, 1'b0, 1'b1); // zero with V and C set

        finished = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL R6 watchdog: got=timeout exp=done");
            report();
            $finish;
        end
    end
endmodule